// File: doc/BRIEF.md
# Byte-Granular Copy, Rectangle and Fill Mover

This block moves bytes through system memory on command. A job is handed over as a set of descriptor inputs and a one-cycle start pulse. The block then issues word-wide read and write requests on a single request port until the job is complete. It raises a one-cycle done pulse when the last write has been accepted.

A job runs in one of three ways. A linear copy moves a byte count from a source address to a destination address, and either address may be unaligned. A rectangle copy reads one contiguous source and writes it as a number of equal runs, with each run starting one stride after the start of the previous run. A fill writes a constant taken from the source-address field in place of fetched data, and it can be applied to either a linear or a rectangular destination.

Data from the source passes through a small byte queue that realigns it. Partial words at either end of a run are written with byte strobes, so bytes outside the destination region are never altered.

Top module: `blit_fill_mover`

## Requirements
- R1: A linear copy (rect_en_i=0, fill_en_i=0) writes byte src+i into destination dst+i for every i below len_i, for any source and destination alignment. No byte outside the destination range changes.
- R2: Every request address is word aligned. On a write, strobe bit L enables byte lane L, which is the byte at address (req_addr_o + L). The strobes of each write are non-zero and contiguous, and they cover only destination bytes. The writes of a run go out in ascending address order, one write for each word the run touches.
- R3: With rect_en_i=1, the source is read contiguously, and run r (counting from 0) is written at dst_addr_i + r*stride_i for len_i bytes. With rect_en_i=0, runs_i and stride_i have no effect.
- R4: With fill_en_i=1, no read request is issued, and the byte at destination address a receives bits [8*(a mod 4)+7 : 8*(a mod 4)] of src_addr_i.
- R5: Fill combined with rect_en_i=1 fills every run of the rectangle with the same lane-aligned constant.
- R6: A job with len_i=0, or with rect_en_i=1 and runs_i=0, raises done_o on the cycle after start, keeps busy_o low and makes no memory request.
- R7: A start pulse received while busy_o is high is ignored. The running job completes unchanged.
- R8: After reset, busy_o, done_o and req_valid_o are low. busy_o is high from the cycle after an accepted start until done_o. done_o is high for exactly one cycle, the cycle after the last write is accepted.
- R9: A request held while req_ready_i is low keeps its address, direction, data and strobes stable. No data is lost however long the stall lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle job start; descriptor sampled here when idle |
| rect_en_i | input | 1 | Rectangular destination mode |
| fill_en_i | input | 1 | Constant fill mode |
| src_addr_i | input | 32 | Source byte address, or fill constant when fill_en_i=1 |
| dst_addr_i | input | 32 | Destination byte address (start of first run) |
| len_i | input | 16 | Byte length (linear) or bytes per run (rectangle) |
| runs_i | input | 16 | Number of runs in rectangle mode |
| stride_i | input | 32 | Byte distance between run starts |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request accepted |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 32 | Word-aligned request address |
| req_wdata_o | output | 32 | Write data, byte lane per address |
| req_be_o | output | 4 | Write byte strobes |
| rsp_valid_i | input | 1 | Read data valid, at least one cycle after read acceptance |
| rsp_rdata_i | input | 32 | Read data word |

## Verification
busy_o is due one cycle after the start edge. done_o is due one cycle after the edge that accepts the final write, or one cycle after the start edge for an empty job. The bench samples every output on the falling edge between two rising edges, where these values are settled. A reference model in the bench derives the exact ordered write list (address, strobes, data) for each job from the requirements, and compares each handshake against it at the edge where the handshake occurs. A stalled request is compared again on the following cycle to confirm it has not changed. After done, the whole memory image and the read count are compared with the expected values.

// File: rtl/mover_pkg.sv
package mover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD,
    ST_RWAIT,
    ST_WR
  } mv_state_e;
endpackage

// File: rtl/mover_byte_buf.sv
// Byte queue: oldest byte at bit 0, pop shifts down, push appends after survivors.
module mover_byte_buf #(
  parameter int NB    = 4,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [8*NB-1:0]   push_data_i,
  input  logic [CW-1:0]     push_cnt_i,
  input  logic              pop_i,
  input  logic [CW-1:0]     pop_cnt_i,
  output logic [8*NB-1:0]   head_o,
  output logic [CW-1:0]     cnt_o
);
  logic [8*DEPTH-1:0] data_q, data_d, shifted;
  logic [CW-1:0]      cnt_q, cnt_d, base;

  always_comb begin
    shifted = pop_i ? (data_q >> {pop_cnt_i, 3'b000}) : data_q;
    base    = pop_i ? (cnt_q - pop_cnt_i) : cnt_q;
    data_d  = shifted;
    cnt_d   = base;
    if (push_i) begin
      for (int j = 0; j < DEPTH; j++) begin
        for (int i = 0; i < NB; i++) begin
          if (CW'(i) < push_cnt_i && CW'(j) == base + CW'(i))
            data_d[8*j +: 8] = push_data_i[8*i +: 8];
        end
      end
      cnt_d = base + push_cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o = data_q[8*NB-1:0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/mover_rd_align.sv
// Drops the bytes below the source offset and counts the useful bytes in a fetched word.
module mover_rd_align #(
  parameter int NB    = 4,
  parameter int OFF_W = 2,
  parameter int CW    = 4,
  parameter int RW    = 32
) (
  input  logic [8*NB-1:0] rdata_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [RW-1:0]   rem_i,
  output logic [8*NB-1:0] data_o,
  output logic [CW-1:0]   cnt_o
);
  logic [CW-1:0] room;

  always_comb begin
    room   = CW'(NB) - CW'(off_i);
    data_o = rdata_i >> {off_i, 3'b000};
    cnt_o  = (rem_i < RW'(room)) ? CW'(rem_i) : room;
  end
endmodule

// File: rtl/mover_wr_fmt.sv
// Builds one destination word: byte count, lane strobes and lane-placed data.
module mover_wr_fmt #(
  parameter int NB    = 4,
  parameter int OFF_W = 2,
  parameter int CW    = 4,
  parameter int LW    = 16
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LW-1:0]    rem_i,
  input  logic             fill_i,
  input  logic [8*NB-1:0]  fill_val_i,
  input  logic [8*NB-1:0]  head_i,
  output logic [CW-1:0]    k_o,
  output logic [NB-1:0]    be_o,
  output logic [8*NB-1:0]  wdata_o
);
  localparam int BW = 2 * NB;

  logic [CW-1:0]     room;
  logic [BW-1:0]     be_w;
  logic [8*NB-1:0]   src_word;

  always_comb begin
    room     = CW'(NB) - CW'(off_i);
    k_o      = (rem_i < LW'(room)) ? CW'(rem_i) : room;
    be_w     = (BW'(1) << k_o) - BW'(1);
    be_w     = be_w << off_i;
    be_o     = be_w[NB-1:0];
    src_word = fill_i ? fill_val_i : (head_i << {off_i, 3'b000});
    for (int l = 0; l < NB; l++)
      wdata_o[8*l +: 8] = be_o[l] ? src_word[8*l +: 8] : 8'h00;
  end
endmodule

// File: rtl/blit_fill_mover.sv
module blit_fill_mover
  import mover_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LW        = 16,
  parameter int BUF_WORDS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rect_en_i,
  input  logic          fill_en_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] runs_i,
  input  logic [AW-1:0] stride_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic [DW/8-1:0] req_be_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  localparam int NB    = DW / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int DEPTH = NB * BUF_WORDS;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int RW    = 2 * LW;

  mv_state_e     st_q;
  logic          fill_q, done_q, we_q;
  logic [DW-1:0] fill_val_q, wdata_q;
  logic [AW-1:0] src_q, dst_q, base_q, stride_q, addr_q;
  logic [LW-1:0] run_len_q, run_rem_q, runs_q;
  logic [RW-1:0] rd_rem_q;
  logic [NB-1:0] be_q;
  logic [CW-1:0] wr_k_q;

  logic [LW-1:0] runs_n;
  logic          zero_job;
  logic          buf_push, buf_pop;
  logic [DW-1:0] buf_head, ra_data, wf_wdata;
  logic [CW-1:0] buf_cnt, ra_cnt, wf_k;
  logic [NB-1:0] wf_be;

  assign runs_n   = rect_en_i ? runs_i : LW'(1);
  assign zero_job = (len_i == '0) || (runs_n == '0);
  assign buf_push = (st_q == ST_RWAIT) && rsp_valid_i;
  assign buf_pop  = (st_q == ST_WR) && req_ready_i && !fill_q;

  mover_byte_buf #(.NB(NB), .DEPTH(DEPTH), .CW(CW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (buf_push),
    .push_data_i (ra_data),
    .push_cnt_i  (ra_cnt),
    .pop_i       (buf_pop),
    .pop_cnt_i   (wr_k_q),
    .head_o      (buf_head),
    .cnt_o       (buf_cnt)
  );

  mover_rd_align #(.NB(NB), .OFF_W(OFF_W), .CW(CW), .RW(RW)) u_ralign (
    .rdata_i (rsp_rdata_i),
    .off_i   (src_q[OFF_W-1:0]),
    .rem_i   (rd_rem_q),
    .data_o  (ra_data),
    .cnt_o   (ra_cnt)
  );

  mover_wr_fmt #(.NB(NB), .OFF_W(OFF_W), .CW(CW), .LW(LW)) u_wfmt (
    .off_i      (dst_q[OFF_W-1:0]),
    .rem_i      (run_rem_q),
    .fill_i     (fill_q),
    .fill_val_i (fill_val_q),
    .head_i     (buf_head),
    .k_o        (wf_k),
    .be_o       (wf_be),
    .wdata_o    (wf_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      fill_q     <= 1'b0;
      done_q     <= 1'b0;
      we_q       <= 1'b0;
      fill_val_q <= '0;
      wdata_q    <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      base_q     <= '0;
      stride_q   <= '0;
      addr_q     <= '0;
      run_len_q  <= '0;
      run_rem_q  <= '0;
      runs_q     <= '0;
      rd_rem_q   <= '0;
      be_q       <= '0;
      wr_k_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            fill_q     <= fill_en_i;
            fill_val_q <= DW'(src_addr_i);
            src_q      <= src_addr_i;
            dst_q      <= dst_addr_i;
            base_q     <= dst_addr_i;
            stride_q   <= stride_i;
            run_len_q  <= len_i;
            run_rem_q  <= len_i;
            runs_q     <= runs_n;
            rd_rem_q   <= fill_en_i ? '0 : RW'(len_i) * RW'(runs_n);
            if (zero_job) done_q <= 1'b1;
            else          st_q   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          // write as soon as the queue holds the bytes for the next destination word
          if (fill_q || buf_cnt >= wf_k) begin
            we_q    <= 1'b1;
            addr_q  <= {dst_q[AW-1:OFF_W], {OFF_W{1'b0}}};
            wdata_q <= wf_wdata;
            be_q    <= wf_be;
            wr_k_q  <= wf_k;
            st_q    <= ST_WR;
          end else begin
            we_q   <= 1'b0;
            addr_q <= {src_q[AW-1:OFF_W], {OFF_W{1'b0}}};
            be_q   <= '1;
            st_q   <= ST_RD;
          end
        end
        ST_RD: begin
          if (req_ready_i) st_q <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (rsp_valid_i) begin
            src_q    <= src_q + AW'(ra_cnt);
            rd_rem_q <= rd_rem_q - RW'(ra_cnt);
            st_q     <= ST_EVAL;
          end
        end
        ST_WR: begin
          if (req_ready_i) begin
            if (run_rem_q == LW'(wr_k_q)) begin
              if (runs_q == LW'(1)) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                // next run starts one stride after the previous run start
                base_q    <= base_q + stride_q;
                dst_q     <= base_q + stride_q;
                run_rem_q <= run_len_q;
                runs_q    <= runs_q - LW'(1);
                st_q      <= ST_EVAL;
              end
            end else begin
              dst_q     <= dst_q + AW'(wr_k_q);
              run_rem_q <= run_rem_q - LW'(wr_k_q);
              st_q      <= ST_EVAL;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign req_valid_o = (st_q == ST_RD) || (st_q == ST_WR);
  assign req_we_o    = we_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign req_be_o    = be_q;
endmodule

// File: rtl/mover_chk.sv
module mover_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic          req_we_o,
  input logic [AW-1:0] req_addr_o,
  input logic [DW-1:0] req_wdata_o,
  input logic [DW/8-1:0] req_be_o,
  input logic          fill_q
);
  localparam int NB    = DW / 8;
  localparam int OFF_W = $clog2(NB);

  function automatic bit be_contig(logic [NB-1:0] b);
    logic [NB:0] w, x;
    w = {1'b0, b};
    x = w + (w & (-w));
    return (b != '0) && ((x[NB-1:0] & b) == '0);
  endfunction

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_we_o) &&
      $stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_be_o));

  p_fill_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && fill_q |-> req_we_o);

  p_be_contig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_we_o |-> be_contig(req_be_o));

  p_addr_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);
endmodule

bind blit_fill_mover mover_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_we_o    (req_we_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .req_be_o    (req_be_o),
  .fill_q      (fill_q)
);

// File: tb/blit_fill_mover_tb.sv
`timescale 1ns/1ps
module blit_fill_mover_tb_top;
  localparam int MEMSZ = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, rect_en_i = 1'b0, fill_en_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0, stride_i = '0;
  logic [15:0] len_i = '0, runs_i = '0;
  logic        busy_o, done_o, req_valid_o, req_we_o;
  logic        req_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [31:0] req_addr_o, req_wdata_o, rsp_rdata_i = '0;
  logic [3:0]  req_be_o;

  always #4 clk = ~clk;

  blit_fill_mover dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rect_en_i(rect_en_i),
    .fill_en_i(fill_en_i), .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .len_i(len_i), .runs_i(runs_i), .stride_i(stride_i), .busy_o(busy_o),
    .done_o(done_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_we_o(req_we_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .req_be_o(req_be_o), .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } wr_t;

  logic [7:0] mem     [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];
  wr_t        wq[$];
  int         n_chk = 0, n_err = 0, rd_count = 0, wr_count = 0, cycles = 0;
  bit         done_due = 0, chk_done_en = 0, hold_chk = 0, rsp_pend = 0, finished = 0;
  int         rsp_dly = 0;
  logic [31:0] rsp_word, h_addr, h_data;
  logic [3:0]  h_be;
  logic        h_we;
  string       cur_req = "R1";

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference memory and request monitor, evaluated between rising edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_due) begin
        chk(done_o, "R8", "done one cycle after last write", done_o, 1);
        done_due = 0;
      end else if (chk_done_en && done_o) begin
        chk(0, "R8", "done outside its cycle", done_o, 0);
      end
      rsp_valid_i = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 0) begin
          rsp_valid_i = 1'b1;
          rsp_rdata_i = rsp_word;
          rsp_pend = 0;
        end else rsp_dly--;
      end
      if (hold_chk) begin
        chk(req_valid_o && req_we_o == h_we && req_addr_o == h_addr &&
            req_be_o == h_be && req_wdata_o == h_data, "R9", "stalled request changed",
            {req_valid_o, req_addr_o, req_be_o, req_wdata_o}, {1'b1, h_addr, h_be, h_data});
        hold_chk = 0;
      end
      req_ready_i = ($urandom_range(0, 9) < 6);
      if (req_valid_o && req_ready_i) begin
        if (req_we_o) begin
          wr_count++;
          if (wq.size() == 0) begin
            chk(0, "R2", "write beyond expected list", req_addr_o, 0);
          end else begin
            wr_t e;
            e = wq.pop_front();
            chk(req_addr_o == e.addr && req_be_o == e.be && req_wdata_o == e.data,
                cur_req, "write (R2 order/strobes)",
                {req_addr_o, req_be_o, req_wdata_o}, {e.addr, e.be, e.data});
            if (wq.size() == 0) done_due = 1;
          end
          for (int l = 0; l < 4; l++)
            if (req_be_o[l]) mem[(req_addr_o + l) % MEMSZ] = req_wdata_o[8*l +: 8];
        end else begin
          rd_count++;
          for (int l = 0; l < 4; l++) rsp_word[8*l +: 8] = mem[(req_addr_o + l) % MEMSZ];
          rsp_pend = 1;
          rsp_dly  = $urandom_range(0, 2);
        end
      end else if (req_valid_o) begin
        hold_chk = 1;
        h_we = req_we_o; h_addr = req_addr_o; h_be = req_be_o; h_data = req_wdata_o;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run_job(string tag, bit rect, bit fill, logic [31:0] src, logic [31:0] dst,
                         int n, int m, logic [31:0] stride, bit zero, bit poke);
    int runs, idx, rd0, wr0, t, bad;
    runs = rect ? m : 1;
    exp_mem = mem;
    wq.delete();
    idx = 0;
    if (!zero) begin
      for (int r = 0; r < runs; r++) begin
        int a, rem;
        a = dst + r * stride;
        rem = n;
        while (rem > 0) begin
          wr_t e;
          int off, k;
          off = a % 4;
          k = (4 - off < rem) ? 4 - off : rem;
          e.addr = a & ~32'h3; e.be = '0; e.data = '0;
          for (int i = 0; i < k; i++) begin
            logic [7:0] b;
            b = fill ? src[8*((a + i) % 4) +: 8] : mem[(src + idx) % MEMSZ];
            idx++;
            e.be[off + i] = 1'b1;
            e.data[8*(off + i) +: 8] = b;
            exp_mem[(a + i) % MEMSZ] = b;
          end
          wq.push_back(e);
          a += k; rem -= k;
        end
      end
    end
    rd0 = rd_count; wr0 = wr_count;
    cur_req = tag;
    chk_done_en = !zero;
    start_i = 1'b1; rect_en_i = rect; fill_en_i = fill; src_addr_i = src;
    dst_addr_i = dst; len_i = 16'(n); runs_i = 16'(m); stride_i = stride;
    @(negedge clk);
    start_i = 1'b0;
    if (zero) begin
      chk(done_o, "R6", "done one cycle after empty start", done_o, 1);
      chk(!busy_o, "R6", "busy on empty job", busy_o, 0);
      @(negedge clk);
      chk(!done_o && !req_valid_o, "R6", "done pulse/quiet port", {done_o, req_valid_o}, 0);
      chk(rd_count == rd0 && wr_count == wr0, "R6", "memory accesses on empty job",
          rd_count - rd0 + wr_count - wr0, 0);
    end else begin
      chk(busy_o, "R8", "busy one cycle after start", busy_o, 1);
      t = 0;
      while (!done_o && t < 20000) begin
        if (poke && t == 3) begin
          start_i = 1'b1; fill_en_i = 1'b1; src_addr_i = 32'hDEADBEEF;
          dst_addr_i = 32'h0; len_i = 16'd8; rect_en_i = 1'b0;
        end else start_i = 1'b0;
        @(negedge clk);
        t++;
      end
      start_i = 1'b0;
      chk(done_o, tag, "job completion", done_o, 1);
      chk(wq.size() == 0, tag, "writes left unissued", wq.size(), 0);
      bad = 0;
      for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, tag, "memory image mismatched bytes", bad, 0);
      if (fill) chk(rd_count == rd0, "R4", "reads issued in fill", rd_count - rd0, 0);
      @(negedge clk);
      chk(!done_o && !busy_o, "R8", "done single cycle and idle", {done_o, busy_o}, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !req_valid_o, "R8", "reset state",
        {busy_o, done_o, req_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_job("R1", 0, 0, 32'h100, 32'h200, 16, 0, 0, 0, 0);
    run_job("R1", 0, 0, 32'h101, 32'h213, 13, 0, 0, 0, 0);
    run_job("R2", 0, 0, 32'h10f, 32'h22e, 3, 0, 0, 0, 0);
    run_job("R2", 0, 0, 32'h113, 32'h241, 1, 0, 0, 0, 0);
    run_job("R3", 0, 0, 32'h120, 32'h260, 7, 0, 32'h7777, 0, 0);
    run_job("R3", 1, 0, 32'h105, 32'h301, 6, 3, 20, 0, 0);
    run_job("R4", 0, 1, 32'hA1B2C3D4, 32'h282, 9, 0, 0, 0, 0);
    run_job("R5", 1, 1, 32'h5A6B7C8D, 32'h343, 5, 4, 16, 0, 0);
    run_job("R6", 0, 0, 32'h100, 32'h380, 0, 5, 4, 1, 0);
    run_job("R6", 1, 0, 32'h100, 32'h380, 4, 0, 8, 1, 0);
    run_job("R7", 0, 0, 32'h140, 32'h3c1, 11, 0, 0, 0, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule